// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffers

This block sits next to a data cache and keeps several short queues of cache lines that were fetched ahead of demand. Each queue follows one run of consecutive line addresses. Prefetched lines stay in the queues and reach the cache only when a miss asks for them. When the cache misses, it presents the line address on the miss port. The block compares that address with the oldest entry of every active queue in the same cycle. On a match it hands back the line for the cache fill. Without a match it claims a queue, using the least-recently-used one if none is idle, and restarts that queue at the line after the miss.

Queues top themselves up through a single request/response memory port. In any cycle the bus is reported idle, one queue with a free slot is picked in rotating order and asks for its next line. Each request carries a tag naming the queue, the slot and the queue's generation. Memory returns the tag unchanged, so replies for lines of a queue that has since been restarted are thrown away.

Top module: `seqbuf_top`

## Requirements
- R1: While reset is high and on the first cycle after it, miss_ready is 1 and fill_valid, alloc_valid and mem_req_valid are 0. All queues are inactive.
- R2: A miss is compared only with the oldest entry of each active queue. A line held deeper in a queue, or a queue with no entry at all, does not match, and the miss then leads to an allocation.
- R3: When the matching oldest entry already holds its data, fill_valid is high in the cycle after the edge that took the miss. fill_line then equals the miss line and fill_data equals the data memory returned for that line. The entry is removed, so the next line of that run becomes the oldest. With several matches, the lowest-numbered queue serves the miss.
- R4: When the matching oldest entry is still waiting for memory, miss_ready drops after the miss is taken and no result is given. Once the data has arrived, the fill is given as in R3 and miss_ready returns to 1.
- R5: A miss without a match raises alloc_valid for one cycle, with alloc_buf naming the chosen queue. The lowest-numbered inactive queue is chosen first. The chosen queue is emptied and its next request is for the miss line plus one.
- R6: When every queue is active, allocation takes the least-recently-used queue. Both a hit and an allocation make the touched queue the most recently used.
- R7: A request (mem_req_valid) appears only in the cycle after an edge at which mem_idle was 1. There is at most one request per cycle. The lines a queue requests are consecutive, starting at its allocation line plus one. The tag is {queue index, slot, generation}, with the queue index in the top bits.
- R8: Among queues that want the bus, the grant rotates starting from the queue after the last one granted. After reset, queue 0 comes first.
- R9: A reply whose generation no longer matches its queue is dropped, so every fill carries the data of its own line.
- R10: Every taken miss yields exactly one of fill_valid or alloc_valid, never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache miss lookup request |
| miss_line | input | LINE_W | Line address of the miss |
| miss_ready | output | 1 | Block can take a miss this cycle |
| fill_valid | output | 1 | Fill line returned for a hit |
| fill_line | output | LINE_W | Line address of the fill |
| fill_data | output | DATA_W | Line data of the fill |
| alloc_valid | output | 1 | Miss had no match; a queue was restarted |
| alloc_buf | output | $clog2(NBUF) | Queue that was restarted |
| mem_idle | input | 1 | Memory bus can accept a request |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_line | output | LINE_W | Requested line address |
| mem_req_tag | output | TAG_W | {queue, slot, generation} of the request |
| mem_rsp_valid | input | 1 | Reply data valid |
| mem_rsp_tag | input | TAG_W | Tag echoed from the request |
| mem_rsp_data | input | DATA_W | Reply line data |

## Verification
The bench uses the defaults: four queues of four slots, a 2-bit generation, 26-bit lines and 64-bit data. A memory model answers after four cycles. With only four queues, a short run of misses fills every queue and forces reuse of the least-recently-used one within a few lookups. Four slots make it cheap to plant a target line deep in a queue. The 2-bit generation wraps often enough that a fast phase of back-to-back misses with a randomly idle bus restarts queues while their replies are still in flight.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } seqbuf_state_e;
endpackage

// File: rtl/seqbuf_lane.sv
module seqbuf_lane #(
  parameter int LINE_W = 26,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int GEN_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic [LINE_W-1:0]        flush_line,
  input  logic                     pop,
  input  logic                     grant,
  input  logic                     rsp_we,
  input  logic [$clog2(DEPTH)-1:0] rsp_slot,
  input  logic [GEN_W-1:0]         rsp_gen,
  input  logic [DATA_W-1:0]        rsp_data,
  output logic                     active,
  output logic                     want,
  output logic                     head_valid,
  output logic                     head_pend,
  output logic [LINE_W-1:0]        head_line,
  output logic [DATA_W-1:0]        head_data,
  output logic [LINE_W-1:0]        req_line,
  output logic [$clog2(DEPTH)-1:0] req_slot,
  output logic [GEN_W-1:0]         cur_gen
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int CNT_W  = SLOT_W + 1;

  logic              act_q;
  logic [GEN_W-1:0]  gen_q;
  logic [LINE_W-1:0] nxt_q;
  logic [SLOT_W-1:0] hd_q, tl_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DEPTH-1:0]  pend_q, pend_n;
  logic [LINE_W-1:0] line_q   [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic              rsp_ok;

  // a reply lands only if it belongs to the live generation of a waiting slot
  assign rsp_ok = rsp_we && !flush && (rsp_gen == gen_q) && pend_q[rsp_slot];

  always_comb begin
    pend_n = pend_q;
    if (rsp_ok) pend_n[rsp_slot] = 1'b0;
    if (grant)  pend_n[tl_q]     = 1'b1;
    cnt_n = cnt_q;
    if (grant) cnt_n = cnt_n + CNT_W'(1);
    if (pop)   cnt_n = cnt_n - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      gen_q  <= '0;
      nxt_q  <= '0;
      hd_q   <= '0;
      tl_q   <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (flush) begin
      act_q  <= 1'b1;
      gen_q  <= gen_q + GEN_W'(1);
      nxt_q  <= flush_line + LINE_W'(1);
      hd_q   <= '0;
      tl_q   <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
      if (grant) begin
        tl_q  <= tl_q + SLOT_W'(1);
        nxt_q <= nxt_q + LINE_W'(1);
      end
      if (pop) hd_q <= hd_q + SLOT_W'(1);
    end
  end

  // storage arrays without reset so they can map to RAM
  always_ff @(posedge clk) begin
    if (grant && !flush) line_q[tl_q] <= nxt_q;
  end

  always_ff @(posedge clk) begin
    if (rsp_ok) data_mem[rsp_slot] <= rsp_data;
  end

  assign active     = act_q;
  assign want       = act_q && (cnt_q != CNT_W'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head_pend  = pend_q[hd_q];
  assign head_line  = line_q[hd_q];
  assign head_data  = data_mem[hd_q];
  assign req_line   = nxt_q;
  assign req_slot   = tl_q;
  assign cur_gen    = gen_q;
endmodule

// File: rtl/seqbuf_rr_arb.sv
module seqbuf_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;

  always_comb begin
    any     = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any && en && req[(int'(last_q) + k) % N]) begin
        any     = 1'b1;
        gnt_idx = IW'((int'(last_q) + k) % N);
      end
    end
    gnt = any ? (N'(1) << gnt_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)      last_q <= IW'(N - 1);
    else if (any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/seqbuf_lru.sv
module seqbuf_lru #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 touch,
  input  logic [$clog2(N)-1:0] touch_idx,
  output logic [$clog2(N)-1:0] lru_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] rank_q [N];
  logic [IW-1:0] touched_rank;

  assign touched_rank = rank_q[touch_idx];

  for (genvar i = 0; i < N; i++) begin : g_rank
    always_ff @(posedge clk) begin
      if (rst) begin
        rank_q[i] <= IW'(i);
      end else if (touch) begin
        if (touch_idx == IW'(i))            rank_q[i] <= '0;
        else if (rank_q[i] < touched_rank)  rank_q[i] <= rank_q[i] + IW'(1);
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (rank_q[i] == IW'(N - 1)) lru_idx = IW'(i);
    end
  end
endmodule

// File: rtl/seqbuf_top.sv
module seqbuf_top #(
  parameter int NBUF   = 4,
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  parameter int DATA_W = 64,
  parameter int GEN_W  = 2,
  localparam int BUF_W  = $clog2(NBUF),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int TAG_W  = BUF_W + SLOT_W + GEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  output logic              miss_ready,
  output logic              fill_valid,
  output logic [LINE_W-1:0] fill_line,
  output logic [DATA_W-1:0] fill_data,
  output logic              alloc_valid,
  output logic [BUF_W-1:0]  alloc_buf,
  input  logic              mem_idle,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [TAG_W-1:0]  mem_req_tag,
  input  logic              mem_rsp_valid,
  input  logic [TAG_W-1:0]  mem_rsp_tag,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  import seqbuf_pkg::*;

  logic [NBUF-1:0]   l_act, l_want, l_hv, l_hp, l_rsp_we;
  logic [NBUF-1:0]   flush_vec, pop_vec, arb_gnt;
  logic [LINE_W-1:0] l_hline    [NBUF];
  logic [LINE_W-1:0] l_req_line [NBUF];
  logic [DATA_W-1:0] l_hdata    [NBUF];
  logic [SLOT_W-1:0] l_req_slot [NBUF];
  logic [GEN_W-1:0]  l_gen      [NBUF];

  logic [BUF_W-1:0]  rsp_buf;
  logic [SLOT_W-1:0] rsp_slot;
  logic [GEN_W-1:0]  rsp_gen;

  assign rsp_buf  = mem_rsp_tag[TAG_W-1 -: BUF_W];
  assign rsp_slot = mem_rsp_tag[GEN_W +: SLOT_W];
  assign rsp_gen  = mem_rsp_tag[GEN_W-1:0];

  for (genvar i = 0; i < NBUF; i++) begin : g_lane
    assign l_rsp_we[i] = mem_rsp_valid && (rsp_buf == BUF_W'(i));
    seqbuf_lane #(
      .LINE_W(LINE_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .GEN_W(GEN_W)
    ) u_lane (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush_vec[i]),
      .flush_line(miss_line),
      .pop       (pop_vec[i]),
      .grant     (arb_gnt[i]),
      .rsp_we    (l_rsp_we[i]),
      .rsp_slot  (rsp_slot),
      .rsp_gen   (rsp_gen),
      .rsp_data  (mem_rsp_data),
      .active    (l_act[i]),
      .want      (l_want[i]),
      .head_valid(l_hv[i]),
      .head_pend (l_hp[i]),
      .head_line (l_hline[i]),
      .head_data (l_hdata[i]),
      .req_line  (l_req_line[i]),
      .req_slot  (l_req_slot[i]),
      .cur_gen   (l_gen[i])
    );
  end

  // ---------------- lookup and allocation control ----------------
  seqbuf_state_e    st_q;
  logic [BUF_W-1:0] hold_q;
  logic [NBUF-1:0]  hit_vec;
  logic             hit_any, free_any;
  logic [BUF_W-1:0] hit_idx, free_idx, lru_idx, alloc_idx, pop_idx, touch_idx;
  logic             do_pop, do_alloc, go_hold, touch;

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      hit_vec[i] = l_act[i] && l_hv[i] && (l_hline[i] == miss_line);
      if (!hit_any && hit_vec[i]) begin
        hit_any = 1'b1;
        hit_idx = BUF_W'(i);
      end
      if (!free_any && !l_act[i]) begin
        free_any = 1'b1;
        free_idx = BUF_W'(i);
      end
    end
    alloc_idx = free_any ? free_idx : lru_idx;
  end

  always_comb begin
    do_pop   = 1'b0;
    do_alloc = 1'b0;
    go_hold  = 1'b0;
    pop_idx  = hit_idx;
    if (st_q == ST_HOLD) begin
      pop_idx = hold_q;
      do_pop  = !l_hp[hold_q];
    end else if (miss_valid) begin
      if (hit_any) begin
        if (l_hp[hit_idx]) go_hold = 1'b1;
        else               do_pop  = 1'b1;
      end else begin
        do_alloc = 1'b1;
      end
    end
    touch     = (st_q == ST_IDLE) && miss_valid;
    touch_idx = hit_any ? hit_idx : alloc_idx;
    flush_vec = do_alloc ? (NBUF'(1) << alloc_idx) : '0;
    pop_vec   = do_pop   ? (NBUF'(1) << pop_idx)   : '0;
  end

  seqbuf_lru #(.N(NBUF)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .touch    (touch),
    .touch_idx(touch_idx),
    .lru_idx  (lru_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
    end else if (go_hold) begin
      st_q   <= ST_HOLD;
      hold_q <= hit_idx;
    end else if (st_q == ST_HOLD && do_pop) begin
      st_q   <= ST_IDLE;
    end
  end

  assign miss_ready = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_valid  <= 1'b0;
      alloc_valid <= 1'b0;
      alloc_buf   <= '0;
    end else begin
      fill_valid  <= do_pop;
      alloc_valid <= do_alloc;
      if (do_alloc) alloc_buf <= alloc_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_pop) begin
      fill_line <= l_hline[pop_idx];
      fill_data <= l_hdata[pop_idx];
    end
  end

  // ---------------- refill requests ----------------
  logic [BUF_W-1:0] gnt_idx;
  logic             gnt_any;

  seqbuf_rr_arb #(.N(NBUF)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .en     (mem_idle),
    .req    (l_want & ~flush_vec),
    .gnt    (arb_gnt),
    .gnt_idx(gnt_idx),
    .any    (gnt_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
      mem_req_tag   <= '0;
    end else begin
      mem_req_valid <= gnt_any;
      if (gnt_any) begin
        mem_req_line <= l_req_line[gnt_idx];
        mem_req_tag  <= {gnt_idx, l_req_slot[gnt_idx], l_gen[gnt_idx]};
      end
    end
  end
endmodule

// File: rtl/seqbuf_checker.sv
module seqbuf_checker #(
  parameter int NBUF = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            miss_valid,
  input logic            miss_ready,
  input logic            fill_valid,
  input logic            alloc_valid,
  input logic            mem_idle,
  input logic            mem_req_valid,
  input logic [NBUF-1:0] gnt_vec
);
  assert_req_idle_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> $past(mem_idle));

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_vec));

  assert_fill_cause_R3: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> ($past(miss_valid) || $past(!miss_ready)));

  assert_alloc_cause_R5: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |-> $past(miss_valid && miss_ready));

  assert_one_result_R10: assert property (@(posedge clk) disable iff (rst)
    !(fill_valid && alloc_valid));

  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(miss_ready) |-> (!fill_valid && !alloc_valid));
endmodule

bind seqbuf_top seqbuf_checker #(.NBUF(NBUF)) u_seqbuf_checker (
  .clk          (clk),
  .rst          (rst),
  .miss_valid   (miss_valid),
  .miss_ready   (miss_ready),
  .fill_valid   (fill_valid),
  .alloc_valid  (alloc_valid),
  .mem_idle     (mem_idle),
  .mem_req_valid(mem_req_valid),
  .gnt_vec      (arb_gnt)
);

// File: tb/seqbuf_top_bench.sv
module seqbuf_top_bench;
  localparam int NB  = 4;
  localparam int LW  = 26;
  localparam int DW  = 64;
  localparam int TW  = 6;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          miss_valid;
  logic [LW-1:0] miss_line;
  logic          miss_ready;
  logic          fill_valid;
  logic [LW-1:0] fill_line;
  logic [DW-1:0] fill_data;
  logic          alloc_valid;
  logic [1:0]    alloc_buf;
  logic          mem_idle;
  logic          mem_req_valid;
  logic [LW-1:0] mem_req_line;
  logic [TW-1:0] mem_req_tag;
  logic          mem_rsp_valid;
  logic [TW-1:0] mem_rsp_tag;
  logic [DW-1:0] mem_rsp_data;

  always #10 clk = ~clk;

  seqbuf_top u_seqbuf_top (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_ready(miss_ready),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .alloc_valid(alloc_valid), .alloc_buf(alloc_buf),
    .mem_idle(mem_idle), .mem_req_valid(mem_req_valid),
    .mem_req_line(mem_req_line), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_checks = 0;
  int n_errors = 0;

  function automatic logic [DW-1:0] line_data(input logic [LW-1:0] l);
    return {32'(l) * 32'h9E3779B1, 32'(l) ^ 32'h5A5A5A5A};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model and request monitor ----------------
  int            mode = 2;          // 0 random idle, 1 idle, 2 busy, 3 one idle cycle
  logic [LW-1:0] cur_miss = '0;
  logic [LW-1:0] exp_next [NB];
  logic [LW-1:0] q_line [16];
  logic [TW-1:0] q_tag  [16];
  bit            q_v    [16];
  int            rlog_n = 0;
  int            rlog_buf [8];
  int unsigned   cyc = 0;

  initial begin
    for (int i = 0; i < 16; i++) q_v[i] = 1'b0;
    for (int i = 0; i < NB; i++) exp_next[i] = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_tag   = '0;
    mem_rsp_data  = '0;
    mem_idle      = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
      if (!rst) begin
        if (alloc_valid) exp_next[alloc_buf] = cur_miss + LW'(1);
        if (mem_req_valid) begin
          int b;
          b = int'(mem_req_tag[TW-1 -: 2]);
          check(mem_idle == 1'b1, "R7 request without idle bus", 64'(mem_idle), 64'd1);
          check(mem_req_line == exp_next[b], "R7 consecutive line", 64'(mem_req_line), 64'(exp_next[b]));
          exp_next[b] = mem_req_line + LW'(1);
          if (rlog_n < 8) begin
            rlog_buf[rlog_n] = b;
            rlog_n++;
          end
          q_line[(cyc + LAT) % 16] = mem_req_line;
          q_tag[(cyc + LAT) % 16]  = mem_req_tag;
          q_v[(cyc + LAT) % 16]    = 1'b1;
        end
      end
      if (q_v[cyc % 16]) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_tag   = q_tag[cyc % 16];
        mem_rsp_data  = line_data(q_line[cyc % 16]);
        q_v[cyc % 16] = 1'b0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      case (mode)
        0: mem_idle = 1'($urandom_range(0, 1));
        1: mem_idle = 1'b1;
        3: begin mem_idle = 1'b1; mode = 2; end
        default: mem_idle = 1'b0;
      endcase
    end
  end

  // ---------------- reference model of queue heads ----------------
  bit            m_act [NB];
  logic [LW-1:0] m_head [NB];
  int            m_rank [NB];

  function automatic void m_touch(input int b);
    int r;
    r = m_rank[b];
    for (int i = 0; i < NB; i++) if (m_rank[i] < r) m_rank[i]++;
    m_rank[b] = 0;
  endfunction

  function automatic void m_alloc(input int b, input logic [LW-1:0] l);
    m_act[b]  = 1'b1;
    m_head[b] = l + LW'(1);
    m_touch(b);
  endfunction

  function automatic void m_pop(input int b);
    m_head[b] = m_head[b] + LW'(1);
    m_touch(b);
  endfunction

  function automatic int m_find(input logic [LW-1:0] l);
    for (int i = 0; i < NB; i++) if (m_act[i] && m_head[i] == l) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < NB; i++) if (!m_act[i]) return i;
    for (int i = 0; i < NB; i++) if (m_rank[i] == NB - 1) return i;
    return 0;
  endfunction

  function automatic bit m_all_active();
    for (int i = 0; i < NB; i++) if (!m_act[i]) return 1'b0;
    return 1'b1;
  endfunction

  // ---------------- miss driver ----------------
  int            r_kind;
  logic [LW-1:0] r_line;
  logic [DW-1:0] r_data;
  int            r_buf;
  int            r_wait;
  logic          r_ready1;

  task automatic do_miss(input logic [LW-1:0] l);
    miss_valid = 1'b1;
    miss_line  = l;
    cur_miss   = l;
    r_kind = 0;
    r_wait = 0;
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    r_ready1 = miss_ready;
    for (int k = 0; k < 60; k++) begin
      if (fill_valid) begin
        r_kind = 1; r_line = fill_line; r_data = fill_data;
        break;
      end
      if (alloc_valid) begin
        r_kind = 2; r_buf = int'(alloc_buf);
        break;
      end
      r_wait++;
      @(negedge clk);
    end
  endtask

  task automatic set_mode(input int v);
    @(posedge clk);
    #2 mode = v;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NB; i++) begin
      m_act[i] = 1'b0; m_head[i] = '0; m_rank[i] = i;
    end
    rst = 1'b1;
    miss_valid = 1'b0;
    miss_line = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(miss_ready == 1'b1, "R1 ready in reset", 64'(miss_ready), 64'd1);
    check(fill_valid == 1'b0 && alloc_valid == 1'b0, "R1 no result in reset",
          64'({fill_valid, alloc_valid}), 64'd0);
    check(mem_req_valid == 1'b0, "R1 no request in reset", 64'(mem_req_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(miss_ready && !fill_valid && !alloc_valid && !mem_req_valid, "R1 state after reset",
          64'({miss_ready, fill_valid, alloc_valid, mem_req_valid}), 64'h8);

    // directed: allocations onto idle queues, bus held busy
    do_miss(LW'(100));
    check(r_kind == 2 && r_buf == 0, "R5 first alloc lowest inactive", 64'(r_buf), 64'd0);
    m_alloc(0, LW'(100));
    do_miss(LW'(101));
    check(r_kind == 2 && r_buf == 1, "R2 empty head does not match", 64'(r_kind * 16 + r_buf), 64'h21);
    m_alloc(1, LW'(101));

    // one idle cycle: queue 0 fetches 101, then a miss finds it pending
    set_mode(3);
    @(negedge clk);
    @(negedge clk);
    do_miss(LW'(101));
    check(r_ready1 == 1'b0, "R4 ready drops while head pending", 64'(r_ready1), 64'd0);
    check(r_kind == 1 && r_wait >= 2, "R4 fill after data arrives", 64'(r_wait), 64'd2);
    check(r_line == LW'(101) && r_data == line_data(LW'(101)), "R4 fill contents",
          64'(r_data), line_data(LW'(101)));
    check(miss_ready == 1'b1, "R4 ready back after fill", 64'(miss_ready), 64'd1);
    m_pop(0);
    check(rlog_n >= 1 && rlog_buf[0] == 0, "R8 queue 0 granted first", 64'(rlog_buf[0]), 64'd0);

    set_mode(3);
    repeat (3) @(negedge clk);
    check(rlog_n >= 2 && rlog_buf[1] == 1, "R8 grant rotates to queue 1", 64'(rlog_buf[1]), 64'd1);

    // deep entry does not match
    set_mode(1);
    repeat (30) @(negedge clk);
    do_miss(LW'(104));
    check(r_kind == 2 && r_buf == 2, "R2 deeper entry ignored", 64'(r_kind * 16 + r_buf), 64'h22);
    m_alloc(2, LW'(104));

    // settled random phase against the model
    for (int it = 0; it < 120; it++) begin
      logic [LW-1:0] l;
      int pick, b, eb;
      set_mode(0);
      repeat ($urandom_range(0, 6)) @(negedge clk);
      set_mode(1);
      repeat (30) @(negedge clk);
      pick = $urandom_range(0, 9);
      b = $urandom_range(0, NB - 1);
      if (pick < 4 && m_act[b])      l = m_head[b];
      else if (pick < 6 && m_act[b]) l = m_head[b] + LW'($urandom_range(1, 3));
      else                           l = LW'($urandom_range(0, 4095));
      eb = m_find(l);
      do_miss(l);
      if (eb >= 0) begin
        check(r_kind == 1 && r_wait == 0, "R3 ready head hit", 64'(r_kind), 64'd1);
        check(r_line == l && r_data == line_data(l), "R3 fill data", 64'(r_data), line_data(l));
        m_pop(eb);
      end else begin
        int vb;
        vb = m_victim();
        if (m_all_active())
          check(r_kind == 2 && r_buf == vb, "R6 least recently used reclaimed",
                64'(r_kind * 16 + r_buf), 64'(32 + vb));
        else
          check(r_kind == 2 && r_buf == vb, "R5 inactive queue claimed",
                64'(r_kind * 16 + r_buf), 64'(32 + vb));
        m_alloc(vb, l);
      end
    end

    // fast phase: back-to-back misses, random bus idle, restarts in flight
    set_mode(0);
    @(negedge clk);
    begin
      logic [LW-1:0] base;
      base = LW'(5000);
      for (int it = 0; it < 300; it++) begin
        logic [LW-1:0] l;
        if ($urandom_range(0, 9) < 7) l = base + LW'($urandom_range(1, 3));
        else                          l = LW'($urandom_range(0, 1023));
        do_miss(l);
        check(r_kind != 0, "R10 miss produced a result", 64'(r_kind), 64'd1);
        if (r_kind == 1)
          check(r_line == l && r_data == line_data(l), "R9 fill data after restarts",
                64'(r_data), line_data(l));
        base = l;
      end
    end

    repeat (10) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule